// File: doc/BRIEF.md
# Hybrid Five-Level Carrier Modulator

This block drives the gates of one phase leg of a five-level inverter. The leg is made of two three-level flying-capacitor stacks. One stack builds the positive half of the output and the other builds the negative half. The block takes a signed reference sample and compares its magnitude against counter-generated triangular carriers. Each stack has two cells whose carriers are half a carrier period apart, so the flying capacitor balances without a control loop. The stack that is not in use keeps its lower switches on, so it adds nothing to the output.

A mode input selects between two carrier schemes:

- **Single-phase mode:** both stacks share one carrier phase.
- **Three-phase mode:** the negative-stack carriers lag the positive-stack carriers by a quarter period. In addition, every carrier is pushed on by a further quarter period each time the sampled reference moves into a different band.

The reference is sampled once per quarter carrier period. That is half the period of the equivalent phase-disposition carrier. Dead time, complementary gate generation and capacitor sensing belong to the surrounding design.

Top module: `hybrid_pwm5`

## Requirements
- R1: While `rst_n` is low, `gate_o` is 0000, the carrier counter is at phase 0, the held reference is 0 and the quarter shift is 0.
- R2: The carrier phase counter `c` runs from 0 to PER-1 and then wraps, advancing once per clock. PER = CLK_HZ/CARRIER_HZ and HALF = PER/2. A carrier at phase `p` has value `p` for `p <= HALF` and `PER - p` otherwise.
- R3: `ref_i` is captured only at clock edges where the pre-edge counter value is a multiple of Q = HALF/2. Changes of `ref_i` at any other edge have no effect on `gate_o`.
- R4: If the held reference has bit 15 clear, only `gate_o[1:0]` (positive stack) may be 1 and `gate_o[3:2]` is 00. If bit 15 is set, only `gate_o[3:2]` (negative stack) may be 1 and `gate_o[1:0]` is 00.
- R5: A cell gate bit is 1 when the level is strictly greater than that cell's carrier value. The level is floor(min(|ref|, 32767) * HALF / 32768). The bit is registered once: the value after edge n uses the counter value that edge n saw and the reference held before it.
- R6: Within a stack, the second cell (`gate_o[1]` or `gate_o[3]`) uses a carrier two quarter periods (half a period) after the first cell's carrier (`gate_o[0]` or `gate_o[2]`).
- R7: With `three_phase_i` low, both stacks use the same carrier phases and the quarter shift is held at 0.
- R8: With `three_phase_i` high, each negative-stack carrier is offset by three quarters (lagging a quarter period) from the matching positive-stack carrier.
- R9: Bands are coded as {bit 15 clear, |ref| >= 16384}. In three-phase mode, a sample whose band differs from the band of the previous sample adds one quarter period to every carrier, modulo four quarters. The value applied at the start is the band of 0, which is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_phase_i | input | 1 | 1 selects three-phase carrier phasing, 0 selects single-phase |
| ref_i | input | 16 | Signed two's-complement reference sample |
| gate_o | output | 4 | Upper-switch gates: [0],[1] positive stack cells, [2],[3] negative stack cells |

## Verification
Constant references tell the cell thresholds and pulse widths apart:

- positive, negative and zero values;
- both full-scale extremes;
- exactly the band boundary, where the two cells of a stack tile the period.

A reference that changes on every clock shows that only quarter-period samples reach the gates. A stepped triangular sweep is run first in single-phase mode and then in three-phase mode. It crosses every band at instants not aligned to the carrier, which separates the static quarter lag from the accumulated dynamic shift. A return to single-phase mode afterwards shows that the shift clears.

// File: rtl/hp5_pkg.sv
package hp5_pkg;
  localparam int REF_W = 16;
  localparam int FS    = (1 << (REF_W - 1)) - 1;

  // magnitude of a signed sample, most negative code saturated to FS
  function automatic int mag_of(logic [REF_W-1:0] r);
    int v;
    v = int'($signed(r));
    if (v < 0) v = -v;
    if (v > FS) v = FS;
    return v;
  endfunction

  // compare level on the carrier scale 0..half
  function automatic int level_of(logic [REF_W-1:0] r, int half);
    return (mag_of(r) * half) / (FS + 1);
  endfunction

  // {positive side, upper half of the magnitude range}
  function automatic logic [1:0] band_of(logic [REF_W-1:0] r);
    return {~r[REF_W-1], mag_of(r) >= (FS + 1) / 2};
  endfunction

  // carrier phase after a shift of k quarters, wrapped into one period
  function automatic int phase_of(int cnt, int k, int q);
    int p;
    p = cnt + k * q;
    if (p >= 4 * q) p = p - 4 * q;
    return p;
  endfunction

  // triangular carrier value for a phase
  function automatic int tri_of(int p, int half);
    return (p <= half) ? p : 2 * half - p;
  endfunction
endpackage

// File: rtl/hp5_carrier_timer.sv
module hp5_carrier_timer #(
  parameter int HALF = 5000,
  localparam int PER = 2 * HALF,
  localparam int Q   = HALF / 2,
  localparam int CW  = $clog2(PER),
  localparam int QW  = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          smp_o
);
  logic [QW-1:0] qc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      qc    <= '0;
    end else begin
      cnt_o <= (cnt_o == CW'(PER - 1)) ? '0 : cnt_o + CW'(1);
      qc    <= (qc == QW'(Q - 1)) ? '0 : qc + QW'(1);
    end
  end

  assign smp_o = (qc == '0);

  AST_CARRIER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CW'(PER - 1)) |=> (cnt_o == '0)); // R2
  AST_SAMPLE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o |-> ((int'(cnt_o) % Q) == 0)); // R3
endmodule

// File: rtl/hp5_ref_sampler.sv
module hp5_ref_sampler
  import hp5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_i,
  input  logic             three_phase_i,
  input  logic [REF_W-1:0] ref_i,
  output logic [REF_W-1:0] ref_q,
  output logic [1:0]       shift_q
);
  logic [1:0] band_q;
  logic       band_cross;

  assign band_cross = smp_i && three_phase_i && (band_of(ref_i) != band_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      band_q  <= 2'b10;
      shift_q <= '0;
    end else begin
      if (smp_i) begin
        ref_q  <= ref_i;
        band_q <= band_of(ref_i);
      end
      if (!three_phase_i)  shift_q <= '0;
      else if (band_cross) shift_q <= shift_q + 2'd1;
    end
  end

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_i |=> $stable(ref_q)); // R3
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    band_cross |=> (shift_q == $past(shift_q) + 2'd1)); // R9
  AST_SHIFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (three_phase_i && !band_cross) |=> $stable(shift_q)); // R9
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !three_phase_i |=> (shift_q == 2'd0)); // R7
endmodule

// File: rtl/hp5_stack_cmp.sv
module hp5_stack_cmp
  import hp5_pkg::*;
#(
  parameter int HALF = 5000,
  parameter int CW   = 14,
  localparam int Q   = HALF / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lvl_i,
  input  logic          en_i,
  input  logic [1:0]    qoff_i,
  output logic [1:0]    gate_o
);
  logic [1:0] hit;

  for (genvar i = 0; i < 2; i++) begin : g_cell
    logic [1:0] k;
    assign k      = qoff_i + 2'(2 * i);
    assign hit[i] = en_i &&
      (int'(lvl_i) > tri_of(phase_of(int'(cnt_i), int'(k), Q), HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_o <= '0;
    else        gate_o <= hit;
  end

  AST_IDLE_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (gate_o == 2'b00)); // R4
  AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == '0) |=> (gate_o == 2'b00)); // R5
endmodule

// File: rtl/hybrid_pwm5.sv
module hybrid_pwm5
  import hp5_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int CARRIER_HZ = 5_000,
  localparam int HALF      = CLK_HZ / (2 * CARRIER_HZ),
  localparam int PER       = 2 * HALF,
  localparam int CW        = $clog2(PER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             three_phase_i,
  input  logic [REF_W-1:0] ref_i,
  output logic [3:0]       gate_o
);
  logic [CW-1:0]    cnt;
  logic             smp;
  logic [REF_W-1:0] ref_q;
  logic [1:0]       shift_q;
  logic [CW-1:0]    lvl;
  logic [1:0]       qoff [2];
  logic             en   [2];

  hp5_carrier_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .smp_o(smp));

  hp5_ref_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .three_phase_i(three_phase_i),
    .ref_i(ref_i), .ref_q(ref_q), .shift_q(shift_q));

  assign lvl     = CW'(level_of(ref_q, HALF));
  assign en[0]   = ~ref_q[REF_W-1];
  assign en[1]   = ref_q[REF_W-1];
  assign qoff[0] = shift_q;
  assign qoff[1] = shift_q + (three_phase_i ? 2'd3 : 2'd0);

  for (genvar s = 0; s < 2; s++) begin : g_stack
    hp5_stack_cmp #(.HALF(HALF), .CW(CW)) u_stack (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .lvl_i(lvl), .en_i(en[s]),
      .qoff_i(qoff[s]), .gate_o(gate_o[2*s +: 2]));
  end

  AST_ONE_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    !((|gate_o[1:0]) && (|gate_o[3:2]))); // R4
endmodule

// File: tb/hybrid_pwm5_tb.sv
module hybrid_pwm5_tb;
  localparam int CLK_HZ = 50_000_000;
  localparam int CAR_HZ = 312_500;
  localparam int HALF   = CLK_HZ / (2 * CAR_HZ);
  localparam int PER    = 2 * HALF;
  localparam int QT     = HALF / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode3 = 1'b0;
  logic [15:0] refv = 16'h0000;
  logic [3:0]  gate;

  always #10 clk = ~clk;

  hybrid_pwm5 #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .three_phase_i(mode3), .ref_i(refv),
    .gate_o(gate));

  typedef struct {
    logic [3:0] exp;
    string      tag;
    int         cyc;
  } item_t;
  item_t sbq[$];

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    run_model = 1'b0;
  bit    done = 1'b0;
  int    cyc = 0;

  // reference model state
  int          m_c = 0;
  logic [15:0] m_ref = 16'h0000;
  int          m_band = 2;
  int          m_sh = 0;

  function automatic int m_mag(logic [15:0] r);
    int v;
    v = r[15] ? 65536 - int'(r) : int'(r);
    return (v > 32767) ? 32767 : v;
  endfunction

  function automatic int m_carrier(int quarters);
    int p;
    p = (m_c + (quarters % 4) * QT) % PER;
    return (p <= HALF) ? p : PER - p;
  endfunction

  function automatic logic [3:0] predict(bit m3);
    int l;
    int base;
    logic [1:0] pair;
    l = (m_mag(m_ref) * HALF) / 32768;
    base = m3 ? m_sh + 3 : m_sh;
    if (m_ref[15]) begin
      pair[0] = l > m_carrier(base);
      pair[1] = l > m_carrier(base + 2);
      return {pair, 2'b00};
    end
    pair[0] = l > m_carrier(m_sh);
    pair[1] = l > m_carrier(m_sh + 2);
    return {2'b00, pair};
  endfunction

  // predictor: one expected item per edge, then advance the model
  always @(posedge clk) begin
    if (run_model) begin
      item_t it;
      int nb;
      it.exp = predict(mode3);
      it.tag = tag;
      it.cyc = cyc;
      sbq.push_back(it);
      if ((m_c % QT) == 0) begin
        nb = (refv[15] ? 0 : 2) + ((m_mag(refv) >= 16384) ? 1 : 0);
        if (mode3 && nb != m_band) m_sh = (m_sh + 1) % 4;
        m_ref  = refv;
        m_band = nb;
      end
      if (!mode3) m_sh = 0;
      m_c = (m_c + 1) % PER;
      cyc++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (gate !== it.exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d gate_o got %b expected %b",
                 it.tag, it.cyc, gate, it.exp);
      end
    end
  end

  task automatic hold(logic [15:0] v, bit m, int cycles, string t);
    @(negedge clk);
    refv  = v;
    mode3 = m;
    tag   = t;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic sweep(bit m, string t);
    for (int i = 0; i < 18; i++) begin
      int a;
      a = (i < 9) ? -30000 + i * 7500 : 30000 - (i - 9) * 7500;
      hold(16'(a), m, 37, t);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a live reference applied
    refv = 16'd20000;
    repeat (4) @(negedge clk);
    n_chk++;
    if (gate !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset gate_o got %b expected 0000", gate);
    end
    refv = 16'h0000;
    rst_n = 1'b1;
    run_model = 1'b1;
    tag = "R1";
    repeat (QT) @(negedge clk);

    hold(16'd20000, 1'b0, 2 * PER, "R5");
    hold(16'd1000,  1'b0, 2 * PER, "R2");
    hold(-16'sd12000, 1'b0, 2 * PER, "R4");
    hold(16'd0,     1'b0, PER,     "R4");
    hold(16'd16384, 1'b0, 2 * PER, "R6");
    hold(16'd32767, 1'b0, PER,     "R5");
    hold(16'h8000,  1'b0, PER,     "R5");
    // R3: reference changes on every clock
    for (int i = 0; i < 3 * PER; i++) begin
      int v;
      v = (i % 3 == 0) ? 25000 : ((i % 3 == 1) ? -25000 : 5000);
      hold(16'(v), 1'b0, 1, "R3");
    end
    sweep(1'b0, "R7");
    hold(16'd10000, 1'b1, 2 * PER, "R8");
    hold(-16'sd10000, 1'b1, 2 * PER, "R8");
    sweep(1'b1, "R9");
    hold(16'd24000, 1'b0, 2 * PER, "R9");
    hold(16'd0, 1'b0, 4, "R1");
    repeat (3) @(negedge clk);
    run_model = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule